// File: doc/BRIEF.md
# Three-Level Interrupt Dispatch Controller

This block takes a set of interrupt request lines and chooses the single vector to present to a processor. Each line carries a two-bit level code: none, low, medium or high. Each of the three levels has its own enable. The highest eligible level wins. Within the medium and high levels, the lowest line index wins. The low level can rotate its order so that every low source is served in turn.

The controller keeps one active bit per level. The processor's acknowledge of a presented vector sets the bit for that vector's level. A dedicated return strobe clears the highest active bit. A request can interrupt running service only when its level is strictly above every active level, so a higher level nests over a lower one.

The rotation of the low level is kept in a start pointer that holds one past the last low vector served. This pointer always shapes the low-level order. When rotation is switched off, the pointer keeps its value. Writing zero to it restores plain index order.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, no level is active, the low-level start pointer is zero, and no vector is presented while no line requests.
- R2: A line takes part only when its request bit is high, its level code is nonzero (1 = low, 2 = medium, 3 = high) and the enable bit of that level is set (bit 0 low, bit 1 medium, bit 2 high).
- R3: Within the medium or high level, the candidate with the lowest line index is presented.
- R4: When several levels have candidates, a candidate of the highest such level is presented, and `vec_lvl` reports its level code.
- R5: Only a level strictly above the highest active level is offered. Otherwise `vec_valid` stays low, while any higher level still preempts.
- R6: An acknowledge while `vec_valid` is high sets the active bit of the presented level at the next clock edge.
- R7: A return strobe clears only the highest set active bit at the next clock edge. Without acknowledge or return, the active bits do not change.
- R8: With rotation enabled, acknowledging low vector v moves the start pointer to v+1 (wrapping to 0). The low-level search then begins at that index, so v has the lowest low-level priority.
- R9: With rotation disabled, acknowledges leave the start pointer unchanged, but the low-level search still begins at it. A pointer write loads `rr_wdata` at the next edge and takes precedence over an acknowledge update, and writing 0 restores lowest-index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_SRC | Request line per source |
| irq_lvl | input | 2*NUM_SRC | Level code per source, source i in bits [2i+1:2i] |
| lvl_en | input | 3 | Enable per level (bit 0 low, bit 1 medium, bit 2 high) |
| rr_en | input | 1 | Rotating order for the low level |
| rr_wr | input | 1 | Load the low-level start pointer |
| rr_wdata | input | VEC_W | Value for the start pointer |
| ack | input | 1 | Processor accepts the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | A vector is presented |
| vec_num | output | VEC_W | Presented vector index |
| vec_lvl | output | 2 | Level code of the presented vector |
| lvl_active | output | 3 | Level in service per bit (bit 0 low, bit 1 medium, bit 2 high) |

## Verification
The vector, valid flag and level outputs are combinational, so they are due in the same cycle as a change of request, level code or enable. The active bits and the start pointer change at the first clock edge after an acknowledge, return or pointer write. Their effect shows in the cycle after that edge. The bench changes inputs just after a rising edge and queues the expected outputs for that cycle. The monitor then compares them at the falling edge, so each expectation for a state change is queued in the cycle following its stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_MED  = 2'd2,
    LV_HIGH = 2'd3
  } lvl_e;

  localparam int NUM_LVL = 3;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 16,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cand,
  input  logic [W-1:0] start,
  output logic         found,
  output logic [W-1:0] idx
);
  logic [W:0] pos;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      pos = {1'b0, start} + (W+1)'(i);
      if (pos >= (W+1)'(N)) pos = pos - (W+1)'(N);
      if (!found && cand[pos[W-1:0]]) begin
        found = 1'b1;
        idx   = pos[W-1:0];
      end
    end
  end

  AST_PICK_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[idx]); // R3
endmodule

// File: rtl/irq_lvl_state.sv
module irq_lvl_state
  import irq_pkg::*;
#(
  parameter int N = 16,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  lvl_e         fire_lvl,
  input  logic [W-1:0] fire_vec,
  input  logic         reti,
  input  logic         rr_en,
  input  logic         rr_wr,
  input  logic [W-1:0] rr_wdata,
  output logic [2:0]   active_q,
  output logic [W-1:0] ptr_q
);
  logic [2:0]   active_d;
  logic [W-1:0] ptr_d;
  logic         act_ce;
  logic         ptr_ce;
  logic [W:0]   nxt_ptr;

  always_comb begin
    active_d = active_q;
    if (reti) begin
      if (active_q[2])      active_d[2] = 1'b0;
      else if (active_q[1]) active_d[1] = 1'b0;
      else                  active_d[0] = 1'b0;
    end
    if (fire && fire_lvl != LV_NONE) active_d[fire_lvl - 2'd1] = 1'b1;
    act_ce = fire | reti;
  end

  always_comb begin
    nxt_ptr = {1'b0, fire_vec} + 1'b1;
    if (nxt_ptr >= (W+1)'(N)) nxt_ptr = '0;
    ptr_d  = ptr_q;
    ptr_ce = 1'b0;
    if (rr_wr) begin
      ptr_d  = rr_wdata;
      ptr_ce = 1'b1;
    end else if (fire && rr_en && fire_lvl == LV_LOW) begin
      ptr_d  = nxt_ptr[W-1:0];
      ptr_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (act_ce) active_q <= active_d;
      if (ptr_ce) ptr_q    <= ptr_d;
    end
  end

  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_lvl != LV_NONE) |=> active_q[$past(fire_lvl) - 2'd1]); // R6
  AST_RETI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !fire && active_q != 3'b000) |=>
      ($countones(active_q) == $countones($past(active_q)) - 1)); // R7
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !reti) |=> $stable(active_q)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_wr && !(fire && rr_en)) |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [2*NUM_SRC-1:0] irq_lvl,
  input  logic [2:0]           lvl_en,
  input  logic                 rr_en,
  input  logic                 rr_wr,
  input  logic [VEC_W-1:0]     rr_wdata,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_num,
  output logic [1:0]           vec_lvl,
  output logic [2:0]           lvl_active
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [VEC_W-1:0]   ptr_q;
  logic [2:0]         active_q;
  logic [1:0]         hi_act;
  logic [NUM_SRC-1:0] cand [NUM_LVL];
  logic [2:0]         found;
  logic [VEC_W-1:0]   pick_idx [NUM_LVL];
  lvl_e               sel_lvl;
  logic               fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    if (active_q[2])      hi_act = 2'd3;
    else if (active_q[1]) hi_act = 2'd2;
    else if (active_q[0]) hi_act = 2'd1;
    else                  hi_act = 2'd0;
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_comb begin
      for (int i = 0; i < NUM_SRC; i++)
        cand[g][i] = irq_req[i] && lvl_en[g] && (irq_lvl[2*i +: 2] == 2'(g + 1));
    end
    irq_pick #(.N(NUM_SRC), .W(VEC_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_int_n),
      .cand  (cand[g]),
      .start ((g == 0) ? ptr_q : '0),
      .found (found[g]),
      .idx   (pick_idx[g])
    );
  end

  always_comb begin
    vec_valid = 1'b0;
    vec_num   = '0;
    sel_lvl   = LV_NONE;
    for (int g = 0; g < NUM_LVL; g++) begin
      if (found[g] && 2'(g + 1) > hi_act) begin
        vec_valid = 1'b1;
        vec_num   = pick_idx[g];
        sel_lvl   = lvl_e'(2'(g + 1));
      end
    end
  end

  assign fire       = ack && vec_valid;
  assign vec_lvl    = sel_lvl;
  assign lvl_active = active_q;

  irq_lvl_state #(.N(NUM_SRC), .W(VEC_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fire     (fire),
    .fire_lvl (sel_lvl),
    .fire_vec (vec_num),
    .reti     (reti),
    .rr_en    (rr_en),
    .rr_wr    (rr_wr),
    .rr_wdata (rr_wdata),
    .active_q (active_q),
    .ptr_q    (ptr_q)
  );

  AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_valid |-> (irq_req[vec_num] && irq_lvl[2*vec_num +: 2] == vec_lvl
                   && vec_lvl != 2'd0 && lvl_en[vec_lvl - 2'd1])); // R2
  AST_NO_RENEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_valid |-> !lvl_active[vec_lvl - 2'd1]); // R5
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (lvl_active == 3'b000)); // R1
endmodule

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 4;

  typedef struct {
    logic       valid;
    logic [W-1:0] vec;
    logic [1:0] lvl;
    logic [2:0] act;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [1:0] lvs [N];
  logic [2*N-1:0] irq_lvl;
  logic [2:0] lvl_en = 3'b000;
  logic rr_en = 1'b0, rr_wr = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [W-1:0] rr_wdata = '0;
  logic vec_valid;
  logic [W-1:0] vec_num;
  logic [1:0] vec_lvl;
  logic [2:0] lvl_active;

  exp_t sbq [$];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) irq_lvl[2*i +: 2] = lvs[i];

  irq_level_ctrl #(.NUM_SRC(N), .VEC_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .lvl_en(lvl_en), .rr_en(rr_en), .rr_wr(rr_wr), .rr_wdata(rr_wdata),
    .ack(ack), .reti(reti), .vec_valid(vec_valid), .vec_num(vec_num),
    .vec_lvl(vec_lvl), .lvl_active(lvl_active)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_tests++;
      if (vec_valid !== e.valid || lvl_active !== e.act ||
          (e.valid && (vec_num !== e.vec || vec_lvl !== e.lvl))) begin
        n_fail++;
        $display("FAIL %s: got valid=%0b vec=%0d lvl=%0d act=%b, expected valid=%0b vec=%0d lvl=%0d act=%b",
                 e.tag, vec_valid, vec_num, vec_lvl, lvl_active,
                 e.valid, e.vec, e.lvl, e.act);
      end
    end
  end

  task automatic push(input logic v, input int vec, input int lvl,
                      input logic [2:0] act, input string tag);
    exp_t e;
    e.valid = v; e.vec = W'(vec); e.lvl = 2'(lvl); e.act = act; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic nxt();
    @(posedge clk); #1;
    ack = 1'b0; reti = 1'b0; rr_wr = 1'b0;
  endtask

  task automatic line(input int i, input logic r, input logic [1:0] l);
    irq_req[i] = r; lvs[i] = l;
  endtask

  task automatic serve_low(input int vec, input string tag);
    ack = 1'b1; push(1, vec, 1, 3'b000, tag);
    nxt(); push(0, 0, 0, 3'b001, "R6 low active");
    reti = 1'b1;
    nxt();
  endtask

  initial begin
    for (int i = 0; i < N; i++) lvs[i] = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) nxt();
    push(0, 0, 0, 3'b000, "R1 reset idle");

    nxt(); lvl_en = 3'b111; line(3, 1, 1); line(5, 1, 1);
    push(1, 3, 1, 3'b000, "R9 zero pointer gives index order");
    nxt(); lvl_en = 3'b110;
    push(0, 0, 0, 3'b000, "R2 low level disabled");
    nxt(); lvl_en = 3'b111; line(3, 0, 1); line(5, 0, 1); line(7, 1, 0);
    push(0, 0, 0, 3'b000, "R2 level code zero ignored");
    nxt(); line(3, 1, 1); line(5, 1, 1); line(6, 1, 2); line(2, 1, 2);
    push(1, 2, 2, 3'b000, "R3 R4 medium lowest index");
    nxt(); line(9, 1, 3);
    push(1, 9, 3, 3'b000, "R4 high wins");
    nxt(); line(9, 0, 3); ack = 1'b1;
    push(1, 2, 2, 3'b000, "R4 medium presented on ack");
    nxt();
    push(0, 0, 0, 3'b010, "R5 R6 medium active blocks same and lower");
    nxt(); line(9, 1, 3);
    push(1, 9, 3, 3'b010, "R5 high preempts medium");
    ack = 1'b1;
    nxt();
    push(0, 0, 0, 3'b110, "R6 nested high active");
    nxt(); reti = 1'b1;
    nxt(); line(9, 0, 3);
    push(0, 0, 0, 3'b010, "R7 return clears high only");
    reti = 1'b1;
    nxt();
    push(1, 2, 2, 3'b000, "R7 second return clears medium");
    nxt(); line(2, 0, 2); line(6, 0, 2);
    push(1, 3, 1, 3'b000, "R4 low after medium gone");

    nxt(); rr_en = 1'b1; line(12, 1, 1);
    serve_low(3, "R8 first low");
    push(1, 5, 1, 3'b000, "R8 rotated to 5");
    serve_low(5, "R8 serve 5");
    push(1, 12, 1, 3'b000, "R8 rotated to 12");
    serve_low(12, "R8 serve 12");
    push(1, 3, 1, 3'b000, "R8 wrap to 3");
    serve_low(3, "R8 serve 3");
    rr_en = 1'b0;
    push(1, 5, 1, 3'b000, "R9 pointer kept with rotation off");
    serve_low(5, "R9 serve 5 rotation off");
    push(1, 5, 1, 3'b000, "R9 pointer not advanced");
    rr_wr = 1'b1; rr_wdata = '0;
    push(1, 5, 1, 3'b000, "R9 write not yet applied");
    nxt();
    push(1, 3, 1, 3'b000, "R9 zero write restores index order");
    rr_wr = 1'b1; rr_wdata = W'(10);
    nxt();
    push(1, 12, 1, 3'b000, "R9 written pointer 10");
    nxt(); nxt();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule